// File: doc/BRIEF.md
# Set-Associative Translation Buffer Array

This block is the storage and match logic of a small set-associative translation lookaside buffer. It turns a 32-bit virtual address plus the current process ID into a physical address and a set of page permissions. Pages are 4 KiB. The lookup path is purely combinational. It compares the tag of every way at the selected set in parallel and returns the result of the lowest-numbered way that matches.

A control front end fills the buffer through a single-entry write port and inspects it through a single-entry read port. Both ports address an entry by way and by set. The set is the low bits of the virtual page number. The number of ways, the total entry count and the PID width are parameters. The number of sets is the entry count divided by the way count and must be a power of two. All pins are plain level signals with no handshake. A lookup result is valid in the same cycle as its inputs, and it never stalls.

Top module: `tlb_array`

## Requirements
- R1: Reset clears every tag and data word to zero, so the read port returns zero for every way and set.
- R2: When `wr_en` is high at a rising clock edge, the entry at way `wr_way` and set `wr_vpn[SET_W-1:0]` takes a new tag and a new data word.
  - The tag is built as VPN in bits 31:12, the global flag in bit 11, the valid flag in bit 10 and the PID in bits PID_W-1:0. All other tag bits are zero.
  - The data word keeps only bits 23:0 of `wr_data`: PFN in 19:0, execute in 20, write in 21, read in 22 and cacheable in 23.
  - Before that edge the entry keeps its old contents.
- R3: The read port is combinational. `rd_tag` and `rd_data` show the entry chosen by `rd_way` and `rd_idx` in the same cycle, with `rd_data` bits 31:24 zero.
- R4: A way hits when its tag VPN equals `lk_vaddr[31:12]` and either its global bit is set or its PID field equals `lk_pid`. A non-global entry with another PID misses, and so does an entry in the same set with a different VPN.
- R5: The valid bit takes no part in the hit test. An entry written with valid=0 still hits, and the all-zero reset entries hit VPN 0 with PID 0.
- R6: When several ways hit, the lowest-numbered way is reported on `lk_way` and supplies the outputs.
- R7: On a hit, `lk_paddr` is the hitting entry's PFN shifted left by 12 with `lk_vaddr[11:0]` kept as the page offset.
- R8: On a hit, `lk_rd`, `lk_wr`, `lk_ex` and `lk_cache` are the read, write, execute and cacheable flags of the hitting entry.
- R9: `lk_kind` encodes the access as 0 for read, 1 for write, 2 for instruction fetch and 3 for none.
  - `lk_allowed` is high only on a hit whose matching permission flag is set.
  - `lk_allowed` is never high for kind 3.
- R10: On a miss, `lk_hit`, `lk_way`, `lk_paddr`, all permission flags and `lk_allowed` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Current process ID |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 none |
| lk_hit | output | 1 | A way matched |
| lk_way | output | WAY_W | Lowest matching way |
| lk_paddr | output | 32 | Translated physical address |
| lk_rd | output | 1 | Read permission of the hit |
| lk_wr | output | 1 | Write permission of the hit |
| lk_ex | output | 1 | Execute permission of the hit |
| lk_cache | output | 1 | Cacheable flag of the hit |
| lk_allowed | output | 1 | Hit with the permission the access kind needs |
| wr_en | input | 1 | Write strobe |
| wr_way | input | WAY_W | Way to write |
| wr_vpn | input | 20 | VPN for the tag; low bits pick the set |
| wr_global | input | 1 | Global flag for the tag |
| wr_valid | input | 1 | Valid flag for the tag |
| wr_pid | input | PID_W | PID for the tag |
| wr_data | input | 32 | Data word; bits 23:0 are kept |
| rd_way | input | WAY_W | Way to read |
| rd_idx | input | SET_W | Set to read |
| rd_tag | output | 32 | Tag of the selected entry |
| rd_data | output | 32 | Data of the selected entry |

## Verification
The bench loads two ways of one set with the same VPN, one entry owned by a PID and one global. With the owning PID the lower way must win. A priority encoder reversed or missing would report the higher way and its page frame instead. The bench also plants an entry with valid=0 and probes the untouched reset entries at VPN 0. Logic that wrongly gated on the valid flag would miss both. It further checks a PID mismatch, a same-set VPN alias, kind 3 and upper data bits on a write. A design that ignored the PID, indexed without comparing the full VPN, allowed the "none" kind or stored unmasked data would show the wrong hit, allowed flag or read-back word. Finally, a write is checked both before and after its clock edge, which exposes a write path that acts combinationally.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = 32 - PAGE_SHIFT;
  localparam int TAG_GLB    = 11;
  localparam int TAG_VLD    = 10;
  localparam int PFN_W      = 20;
  localparam int DATA_W     = 24;
  localparam int D_EXEC     = 20;
  localparam int D_WRIT     = 21;
  localparam int D_READ     = 22;
  localparam int D_CACH     = 23;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/tlb_way_bank.sv
module tlb_way_bank
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int PID_W = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SET_W-1:0]  w_idx,
  input  logic [31:0]       w_tag,
  input  logic [DATA_W-1:0] w_data,
  input  logic [VPN_W-1:0]  l_vpn,
  input  logic [PID_W-1:0]  l_pid,
  output logic              l_match,
  output logic [DATA_W-1:0] l_data,
  input  logic [SET_W-1:0]  r_idx,
  output logic [31:0]       r_tag,
  output logic [DATA_W-1:0] r_data
);
  logic [31:0]       tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];
  logic [SET_W-1:0]  l_idx;
  logic [31:0]       l_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        data_q[s] <= '0;
      end
    end else if (we) begin
      tag_q[w_idx]  <= w_tag;
      data_q[w_idx] <= w_data;
    end
  end

  always_comb begin
    l_idx   = l_vpn[SET_W-1:0];
    l_tag   = tag_q[l_idx];
    l_data  = data_q[l_idx];
    l_match = (l_tag[31:PAGE_SHIFT] == l_vpn) &&
              (l_tag[TAG_GLB] || (l_tag[PID_W-1:0] == l_pid));
    r_tag   = tag_q[r_idx];
    r_data  = data_q[r_idx];
  end

  // R2: a write strobe lands in the addressed set on the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (tag_q[$past(w_idx)] == $past(w_tag)) && (data_q[$past(w_idx)] == $past(w_data)));
endmodule

// File: rtl/tlb_way_pick.sv
module tlb_way_pick #(
  parameter int NW = 4,
  localparam int WAY_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    match,
  output logic             hit,
  output logic [WAY_W-1:0] way,
  output logic [NW-1:0]    sel
);
  always_comb begin
    hit = 1'b0;
    way = '0;
    sel = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit = 1'b1;
        way = WAY_W'(w);
        sel = NW'(1) << w;
      end
    end
  end

  // R6: one way at most is selected
  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && (hit == (|match)));
  // R6: the reported way matches and no lower way does
  p_lowest_way_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match[way] && ((match & ~({NW{1'b1}} << way)) == '0));
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS    = 4,
  parameter int NUM_ENTRIES = 64,
  parameter int PID_W       = 8,
  localparam int SETS  = NUM_ENTRIES / NUM_WAYS,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [1:0]       lk_kind,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way,
  output logic [31:0]      lk_paddr,
  output logic             lk_rd,
  output logic             lk_wr,
  output logic             lk_ex,
  output logic             lk_cache,
  output logic             lk_allowed,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_global,
  input  logic             wr_valid,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [31:0]      wr_data,
  input  logic [WAY_W-1:0] rd_way,
  input  logic [SET_W-1:0] rd_idx,
  output logic [31:0]      rd_tag,
  output logic [31:0]      rd_data
);
  initial begin
    assert ((SETS & (SETS - 1)) == 0 && SETS * NUM_WAYS == NUM_ENTRIES);
    assert (PID_W >= 1 && PID_W <= TAG_VLD);
  end

  logic [31:0]       new_tag;
  logic [NUM_WAYS-1:0] match, sel;
  logic [DATA_W-1:0] l_data [NUM_WAYS];
  logic [31:0]       r_tag  [NUM_WAYS];
  logic [DATA_W-1:0] r_data [NUM_WAYS];
  logic [DATA_W-1:0] hit_data;
  logic              any_hit;
  logic [WAY_W-1:0]  hit_way;
  acc_kind_e         kind;

  always_comb begin
    new_tag = '0;
    new_tag[31:PAGE_SHIFT] = wr_vpn;
    new_tag[TAG_GLB]       = wr_global;
    new_tag[TAG_VLD]       = wr_valid;
    new_tag[PID_W-1:0]     = wr_pid;
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_way_bank #(.SETS(SETS), .PID_W(PID_W)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en && (wr_way == WAY_W'(w))),
      .w_idx   (wr_vpn[SET_W-1:0]),
      .w_tag   (new_tag),
      .w_data  (wr_data[DATA_W-1:0]),
      .l_vpn   (lk_vaddr[31:PAGE_SHIFT]),
      .l_pid   (lk_pid),
      .l_match (match[w]),
      .l_data  (l_data[w]),
      .r_idx   (rd_idx),
      .r_tag   (r_tag[w]),
      .r_data  (r_data[w])
    );
  end

  tlb_way_pick #(.NW(NUM_WAYS)) pick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .match (match),
    .hit   (any_hit),
    .way   (hit_way),
    .sel   (sel)
  );

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (sel[w]) hit_data = hit_data | l_data[w];
    kind       = acc_kind_e'(lk_kind);
    lk_hit     = any_hit;
    lk_way     = hit_way;
    lk_rd      = hit_data[D_READ];
    lk_wr      = hit_data[D_WRIT];
    lk_ex      = hit_data[D_EXEC];
    lk_cache   = hit_data[D_CACH];
    lk_paddr   = any_hit ? {hit_data[PFN_W-1:0], lk_vaddr[PAGE_SHIFT-1:0]} : '0;
    unique case (kind)
      ACC_LOAD:  lk_allowed = lk_rd;
      ACC_STORE: lk_allowed = lk_wr;
      ACC_FETCH: lk_allowed = lk_ex;
      default:   lk_allowed = 1'b0;
    endcase
    rd_tag  = r_tag[rd_way];
    rd_data = {{(32-DATA_W){1'b0}}, r_data[rd_way]};
  end

  // R9: a granted access always needs a hit and never comes from kind 3
  p_allow_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_allowed |-> lk_hit && (lk_kind != 2'd3));
  // R10: a miss leaves every result output quiet
  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0) && !lk_rd && !lk_wr && !lk_ex && !lk_cache && (lk_way == '0));
endmodule

// File: tb/tlb_array_tb_top.sv
module tlb_array_tb_top;
  localparam int PID_W = 8;
  localparam int WAY_W = 2;
  localparam int SET_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [PID_W-1:0] lk_pid = '0;
  logic [1:0] lk_kind = '0;
  logic lk_hit, lk_rd, lk_wr, lk_ex, lk_cache, lk_allowed;
  logic [WAY_W-1:0] lk_way;
  logic [31:0] lk_paddr;
  logic wr_en = 1'b0;
  logic [WAY_W-1:0] wr_way = '0;
  logic [19:0] wr_vpn = '0;
  logic wr_global = 1'b0, wr_valid = 1'b0;
  logic [PID_W-1:0] wr_pid = '0;
  logic [31:0] wr_data = '0;
  logic [WAY_W-1:0] rd_way = '0;
  logic [SET_W-1:0] rd_idx = '0;
  logic [31:0] rd_tag, rd_data;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tlb_array #(.NUM_WAYS(4), .NUM_ENTRIES(64), .PID_W(PID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_way(lk_way), .lk_paddr(lk_paddr), .lk_rd(lk_rd), .lk_wr(lk_wr),
    .lk_ex(lk_ex), .lk_cache(lk_cache), .lk_allowed(lk_allowed), .wr_en(wr_en),
    .wr_way(wr_way), .wr_vpn(wr_vpn), .wr_global(wr_global), .wr_valid(wr_valid),
    .wr_pid(wr_pid), .wr_data(wr_data), .rd_way(rd_way), .rd_idx(rd_idx),
    .rd_tag(rd_tag), .rd_data(rd_data));

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  pid;
    logic [1:0]  kind;
    logic        hit;
    logic [1:0]  way;
    logic [31:0] pa;
    logic [3:0]  perm;   // cache, read, write, exec
    logic        allow;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{32'h00013456, 8'h05, 2'd0, 1'b1, 2'd0, 32'hABCDE456, 4'b0101, 1'b1}, // R6 R9 read
    '{32'h00013456, 8'h05, 2'd1, 1'b1, 2'd0, 32'hABCDE456, 4'b0101, 1'b0}, // R9 write denied
    '{32'h00013456, 8'h05, 2'd2, 1'b1, 2'd0, 32'hABCDE456, 4'b0101, 1'b1}, // R9 fetch
    '{32'h00013FFF, 8'h07, 2'd1, 1'b1, 2'd1, 32'h12345FFF, 4'b0110, 1'b1}, // R4 global
    '{32'h00013000, 8'h07, 2'd2, 1'b1, 2'd1, 32'h12345000, 4'b0110, 1'b0}, // R8
    '{32'h00027010, 8'h09, 2'd3, 1'b1, 2'd2, 32'h00777010, 4'b1111, 1'b0}, // R9 kind 3
    '{32'h00027010, 8'h09, 2'd2, 1'b1, 2'd2, 32'h00777010, 4'b1111, 1'b1}, // R5 valid=0
    '{32'h00027010, 8'h08, 2'd0, 1'b0, 2'd0, 32'h00000000, 4'b0000, 1'b0}, // R4 pid miss
    '{32'h00037000, 8'h09, 2'd2, 1'b1, 2'd3, 32'h00400000, 4'b0001, 1'b1}, // R7
    '{32'h00037000, 8'h09, 2'd0, 1'b1, 2'd3, 32'h00400000, 4'b0001, 1'b0}, // R8
    '{32'h00047ABC, 8'h09, 2'd0, 1'b0, 2'd0, 32'h00000000, 4'b0000, 1'b0}, // R10 alias
    '{32'h00000FFF, 8'h00, 2'd0, 1'b1, 2'd0, 32'h00000FFF, 4'b0000, 1'b0}, // R5 reset entry
    '{32'h00000123, 8'h01, 2'd0, 1'b0, 2'd0, 32'h00000000, 4'b0000, 1'b0}, // R4 reset pid
    '{32'h80013456, 8'h05, 2'd0, 1'b0, 2'd0, 32'h00000000, 4'b0000, 1'b0}  // R10 vpn upper
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] w, input logic [19:0] vpn, input logic g,
                          input logic v, input logic [7:0] pid, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_way = w; wr_vpn = vpn; wr_global = g; wr_valid = v;
    wr_pid = pid; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] pid, input logic [1:0] k);
    lk_vaddr = va; lk_pid = pid; lk_kind = k;
    #1;
  endtask

  task automatic rd(input logic [1:0] w, input logic [3:0] idx);
    rd_way = w; rd_idx = idx;
    #1;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state through the read port
    rd(2'd3, 4'd7);
    chk("R1 tag", rd_tag, 32'h0);
    chk("R1 data", rd_data, 32'h0);

    do_write(2'd0, 20'h00013, 1'b0, 1'b1, 8'h05, 32'hFF5ABCDE);
    do_write(2'd1, 20'h00013, 1'b1, 1'b1, 8'h00, 32'h00612345);
    do_write(2'd2, 20'h00027, 1'b0, 1'b0, 8'h09, 32'h00F00777);
    do_write(2'd3, 20'h00037, 1'b0, 1'b1, 8'h09, 32'h00100400);

    // R2 R3: read back tag layout and masked data, same cycle
    rd(2'd0, 4'd3);
    chk("R2 tag w0", rd_tag, 32'h00013405);
    chk("R2 data mask w0", rd_data, 32'h005ABCDE);
    rd(2'd1, 4'd3);
    chk("R3 tag w1", rd_tag, 32'h00013C00);
    rd(2'd2, 4'd7);
    chk("R3 tag w2", rd_tag, 32'h00027009);
    chk("R3 data w2", rd_data, 32'h00F00777);

    for (int i = 0; i < 14; i++) begin
      look(VECS[i].va, VECS[i].pid, VECS[i].kind);
      chk($sformatf("R4 hit v%0d", i), {31'b0, lk_hit}, {31'b0, VECS[i].hit});
      chk($sformatf("R6 way v%0d", i), {30'b0, lk_way}, {30'b0, VECS[i].way});
      chk($sformatf("R7 paddr v%0d", i), lk_paddr, VECS[i].pa);
      chk($sformatf("R8 perm v%0d", i), {28'b0, lk_cache, lk_rd, lk_wr, lk_ex},
          {28'b0, VECS[i].perm});
      chk($sformatf("R9 allow v%0d", i), {31'b0, lk_allowed}, {31'b0, VECS[i].allow});
    end

    // R2: overwrite is not visible before the edge, then lands
    look(32'h00013456, 8'h05, 2'd0);
    rd(2'd0, 4'd3);
    @(negedge clk);
    wr_en = 1'b1; wr_way = 2'd0; wr_vpn = 20'h00013; wr_global = 1'b0;
    wr_valid = 1'b1; wr_pid = 8'h05; wr_data = 32'h0;
    #1;
    chk("R2 before edge", rd_data, 32'h005ABCDE);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R2 after edge", rd_data, 32'h0);
    chk("R10 no-perm hit paddr", lk_paddr, 32'h00000456);
    chk("R9 no-perm denied", {31'b0, lk_allowed}, 32'h0);

    // R1: reset mid-run clears written entries
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(2'd1, 4'd3);
    chk("R1 reset tag", rd_tag, 32'h0);
    look(32'h00013456, 8'h07, 2'd0);
    chk("R10 miss after reset", {31'b0, lk_hit}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule